// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Index Scheduler

This block steps through the element positions that an in-place radix-2 decimation-in-time FFT touches. It covers a transform of 2 to 64 points. Each time the consumer raises `advance_i`, the block moves to the next butterfly. Between advances it presents one index and three loop-end flags. A two-bit mode picks which operand stream the instance produces: the lower butterfly leg, the upper butterfly leg, or the position in the twiddle-coefficient table. A twin-result butterfly unit is normally fed by three instances that share configuration and the advance strobe and differ only in mode. The unit then receives both data operands and the matching coefficient in the same cycle.

Three loops are nested. The outer loop walks the stages, whose butterfly span doubles from 2 up to n. The middle loop walks the butterfly groups of a stage. The inner loop walks the butterflies inside one group, and the twiddle position moves with it. Each loop can be run in reverse through its own flag. The chosen position is scaled by a power-of-two stride and added to a base offset, so the stream can address a register or memory window directly. After the last butterfly of the last stage, the schedule starts again from the first one.

Top module: `fft_bfly_sched`

## Requirements
- R1: While reset is held, and right after it is released, the outputs show the first butterfly of the schedule for the configuration currently applied.
- R2: Stage s of the forward order (s = 0 .. log2n-1) uses span 2^(s+1) and half-span 2^s, with a twiddle step of n / span. Twiddle positions stay below n/2.
- R3: In a stage, group bases i run over 0, span, 2*span, … below n. In a group, the lower leg j runs from i to i+half-span-1, and every position stays below n. The twiddle position restarts at 0 in each group and grows by the twiddle step with each j.
- R4: Mode code 2'b00 emits j, 2'b01 emits j+half-span, 2'b10 emits the twiddle position, and 2'b11 emits position 0, so that `idx_o` equals the offset.
- R5: `idx_o` equals (selected position << `stride_sh_i`) + `offset_i`, with no wrap in the output width.
- R6: With `inv_stage_i` set, the stages run from span n down to span 2.
- R7: With `inv_blk_i` set, the group bases of each stage run from the highest to 0.
- R8: With `inv_inner_i` set, j and the twiddle position both run backwards inside each group and stay paired as in the forward order.
- R9: `loop_end_o[0]` marks the last butterfly of a group. `loop_end_o[1]` marks the last butterfly of the last group of a stage. `loop_end_o[2]` marks the last butterfly of the whole transform. A higher bit is never set without the lower ones.
- R10: While `advance_i` is low, the index and flags do not change.
- R11: One pass has (n/2)*log2n butterflies. An advance on the final butterfly returns the block to the first butterfly, and the same sequence then repeats.
- R12: `log2n_i` is legal from 1 up to MAX_LOG2N (6 by default). Both extremes produce the full schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| log2n_i | input | LG_W (3) | log2 of the transform length |
| stride_sh_i | input | SHIFT_W (2) | Stride as a left-shift amount |
| offset_i | input | OFF_W (10) | Base added to every scaled position |
| inv_stage_i | input | 1 | Reverse the stage order |
| inv_blk_i | input | 1 | Reverse the group order in each stage |
| inv_inner_i | input | 1 | Reverse j and the twiddle position in each group |
| mode_i | input | 2 | Operand stream select (00 low, 01 high, 10 twiddle, 11 none) |
| advance_i | input | 1 | Step to the next butterfly at this clock edge |
| idx_o | output | IDX_W (11) | Scaled and offset index of the current butterfly |
| loop_end_o | output | 3 | Group, stage and transform end flags |

## Verification
The bench keeps the defaults: MAX_LOG2N = 6, a two-bit stride shift and a ten-bit offset. These values reach the largest 64-point transform, with its 32-wide groups and 192 butterflies, and also the degenerate 2-point case. The top stride shift of 3 together with a large offset drives `idx_o` near the top of its eleven bits. Every inversion flag and every mode, including the unused code, is run against an expected stream that the bench builds from nested loops. Stalls in the middle of a schedule and multi-pass runs cover holding and restart.

// File: rtl/fftsch_pkg.sv
package fftsch_pkg;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_TWID = 2'b10,
    SEL_NONE = 2'b11
  } sel_e;

  // width that holds (max position << max shift) + max offset without wrap
  function automatic int idx_width(input int max_log2n, input int shift_w, input int off_w);
    int scaled_w;
    scaled_w = max_log2n + (1 << shift_w) - 1;
    return ((scaled_w > off_w) ? scaled_w : off_w) + 1;
  endfunction

endpackage

// File: rtl/fftsch_loops.sv
module fftsch_loops #(
  parameter int MAX_LOG2N = 6,
  localparam int LG_W  = $clog2(MAX_LOG2N + 1),
  localparam int CNT_W = MAX_LOG2N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LG_W-1:0]  log2n_i,
  input  logic             inv_stage_i,
  input  logic             advance_i,
  output logic [LG_W-1:0]  eff_stage_o,
  output logic [LG_W-1:0]  blk_exp_o,
  output logic [CNT_W-1:0] hs_m1_o,
  output logic [CNT_W-1:0] nb_m1_o,
  output logic [CNT_W-1:0] blk_q_o,
  output logic [CNT_W-1:0] inner_q_o,
  output logic             inner_last_o,
  output logic             blk_last_o,
  output logic             stage_last_o
);

  logic [LG_W-1:0]  stage_q;
  logic [CNT_W-1:0] blk_q;
  logic [CNT_W-1:0] inner_q;
  logic [LG_W-1:0]  last_stage;

  // 2^e - 1 in CNT_W bits, for e in 0..CNT_W
  function automatic logic [CNT_W-1:0] low_mask(input logic [LG_W-1:0] e);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << e;
    return CNT_W'(one_hot - (CNT_W+1)'(1));
  endfunction

  assign last_stage   = LG_W'(log2n_i - LG_W'(1));
  assign eff_stage_o  = inv_stage_i ? LG_W'(last_stage - stage_q) : stage_q;
  assign blk_exp_o    = LG_W'(last_stage - eff_stage_o);
  assign hs_m1_o      = low_mask(eff_stage_o);
  assign nb_m1_o      = low_mask(blk_exp_o);
  assign inner_last_o = (inner_q == hs_m1_o);
  assign blk_last_o   = (blk_q == nb_m1_o);
  assign stage_last_o = (stage_q == last_stage);
  assign blk_q_o      = blk_q;
  assign inner_q_o    = inner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      blk_q   <= '0;
      inner_q <= '0;
    end else if (advance_i) begin
      if (!inner_last_o) begin
        inner_q <= inner_q + CNT_W'(1);
      end else begin
        inner_q <= '0;
        if (!blk_last_o) begin
          blk_q <= blk_q + CNT_W'(1);
        end else begin
          blk_q   <= '0;
          stage_q <= stage_last_o ? '0 : LG_W'(stage_q + LG_W'(1));
        end
      end
    end
  end

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (log2n_i >= LG_W'(1)) && (log2n_i <= LG_W'(MAX_LOG2N))) else $error("log2n out of range"); // R12

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (inner_q <= hs_m1_o) && (blk_q <= nb_m1_o) && (stage_q <= last_stage)) else $error("counter past limit"); // R3

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable({stage_q, blk_q, inner_q})) else $error("state moved without advance"); // R10

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i && inner_last_o && blk_last_o && stage_last_o |=> (stage_q == '0) && (blk_q == '0) && (inner_q == '0))
    else $error("no restart after final butterfly"); // R11

endmodule

// File: rtl/fftsch_addr.sv
module fftsch_addr
  import fftsch_pkg::*;
#(
  parameter int MAX_LOG2N = 6,
  parameter int SHIFT_W   = 2,
  parameter int OFF_W     = 10,
  localparam int LG_W  = $clog2(MAX_LOG2N + 1),
  localparam int CNT_W = MAX_LOG2N - 1,
  localparam int POS_W = MAX_LOG2N,
  localparam int IDX_W = idx_width(MAX_LOG2N, SHIFT_W, OFF_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LG_W-1:0]    log2n_i,
  input  logic [LG_W-1:0]    eff_stage_i,
  input  logic [LG_W-1:0]    blk_exp_i,
  input  logic [CNT_W-1:0]   hs_m1_i,
  input  logic [CNT_W-1:0]   nb_m1_i,
  input  logic [CNT_W-1:0]   blk_q_i,
  input  logic [CNT_W-1:0]   inner_q_i,
  input  logic               inv_blk_i,
  input  logic               inv_inner_i,
  input  logic [1:0]         mode_i,
  input  logic [SHIFT_W-1:0] stride_sh_i,
  input  logic [OFF_W-1:0]   offset_i,
  output logic [IDX_W-1:0]   idx_o
);

  logic [CNT_W-1:0] grp_eff;
  logic [CNT_W-1:0] pos_eff;
  logic [POS_W-1:0] grp_base;
  logic [POS_W-1:0] half_span;
  logic [POS_W-1:0] lo_pos;
  logic [POS_W-1:0] hi_pos;
  logic [POS_W-1:0] twid_pos;
  logic [POS_W-1:0] sel_pos;

  function automatic logic [CNT_W-1:0] mirror(input logic [CNT_W-1:0] v,
                                               input logic [CNT_W-1:0] last,
                                               input logic en);
    return en ? CNT_W'(last - v) : v;
  endfunction

  function automatic logic [IDX_W-1:0] scale(input logic [POS_W-1:0]   p,
                                             input logic [SHIFT_W-1:0] sh,
                                             input logic [OFF_W-1:0]   off);
    return IDX_W'((IDX_W'(p) << sh) + IDX_W'(off));
  endfunction

  assign grp_eff   = mirror(blk_q_i, nb_m1_i, inv_blk_i);
  assign pos_eff   = mirror(inner_q_i, hs_m1_i, inv_inner_i);
  assign grp_base  = (POS_W'(grp_eff) << eff_stage_i) << 1;
  assign half_span = POS_W'(POS_W'(hs_m1_i) + POS_W'(1));
  assign lo_pos    = POS_W'(grp_base + POS_W'(pos_eff));
  assign hi_pos    = POS_W'(lo_pos + half_span);
  assign twid_pos  = POS_W'(pos_eff) << blk_exp_i;

  always_comb begin
    case (sel_e'(mode_i))
      SEL_LOW:  sel_pos = lo_pos;
      SEL_HIGH: sel_pos = hi_pos;
      SEL_TWID: sel_pos = twid_pos;
      default:  sel_pos = '0;
    endcase
  end

  assign idx_o = scale(sel_pos, stride_sh_i, offset_i);

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != SEL_TWID) |-> ((sel_pos >> log2n_i) == '0)) else $error("leg position beyond n"); // R3

  AST_TWID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SEL_TWID) |-> ((sel_pos >> (log2n_i - LG_W'(1))) == '0)) else $error("twiddle beyond n/2"); // R2

endmodule

// File: rtl/fft_bfly_sched.sv
module fft_bfly_sched
  import fftsch_pkg::*;
#(
  parameter int MAX_LOG2N = 6,
  parameter int SHIFT_W   = 2,
  parameter int OFF_W     = 10,
  localparam int LG_W  = $clog2(MAX_LOG2N + 1),
  localparam int CNT_W = MAX_LOG2N - 1,
  localparam int IDX_W = idx_width(MAX_LOG2N, SHIFT_W, OFF_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LG_W-1:0]    log2n_i,
  input  logic [SHIFT_W-1:0] stride_sh_i,
  input  logic [OFF_W-1:0]   offset_i,
  input  logic               inv_stage_i,
  input  logic               inv_blk_i,
  input  logic               inv_inner_i,
  input  logic [1:0]         mode_i,
  input  logic               advance_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [2:0]         loop_end_o
);

  logic [LG_W-1:0]  eff_stage;
  logic [LG_W-1:0]  blk_exp;
  logic [CNT_W-1:0] hs_m1;
  logic [CNT_W-1:0] nb_m1;
  logic [CNT_W-1:0] blk_q;
  logic [CNT_W-1:0] inner_q;
  logic             inner_last;
  logic             blk_last;
  logic             stage_last;

  fftsch_loops #(.MAX_LOG2N(MAX_LOG2N)) u_loops (
    .clk          (clk),
    .rst_n        (rst_n),
    .log2n_i      (log2n_i),
    .inv_stage_i  (inv_stage_i),
    .advance_i    (advance_i),
    .eff_stage_o  (eff_stage),
    .blk_exp_o    (blk_exp),
    .hs_m1_o      (hs_m1),
    .nb_m1_o      (nb_m1),
    .blk_q_o      (blk_q),
    .inner_q_o    (inner_q),
    .inner_last_o (inner_last),
    .blk_last_o   (blk_last),
    .stage_last_o (stage_last)
  );

  fftsch_addr #(.MAX_LOG2N(MAX_LOG2N), .SHIFT_W(SHIFT_W), .OFF_W(OFF_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .log2n_i     (log2n_i),
    .eff_stage_i (eff_stage),
    .blk_exp_i   (blk_exp),
    .hs_m1_i     (hs_m1),
    .nb_m1_i     (nb_m1),
    .blk_q_i     (blk_q),
    .inner_q_i   (inner_q),
    .inv_blk_i   (inv_blk_i),
    .inv_inner_i (inv_inner_i),
    .mode_i      (mode_i),
    .stride_sh_i (stride_sh_i),
    .offset_i    (offset_i),
    .idx_o       (idx_o)
  );

  assign loop_end_o = {inner_last & blk_last & stage_last, inner_last & blk_last, inner_last};

  AST_END_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_end_o[2] || loop_end_o[1]) && (!loop_end_o[1] || loop_end_o[0])) else $error("loop-end bits not nested"); // R9

  AST_NONE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SEL_NONE) |-> (idx_o == IDX_W'(offset_i))) else $error("unused mode not at offset"); // R4

endmodule

// File: tb/tb_fft_bfly_sched.sv
module tb_fft_bfly_sched;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LOG2N  = 6;
  localparam int SHIFT_W    = 2;
  localparam int OFF_W      = 10;
  localparam int LG_W       = 3;
  localparam int IDX_W      = 11;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [LG_W-1:0]    log2n = 3'd3;
  logic [SHIFT_W-1:0] stride_sh = '0;
  logic [OFF_W-1:0]   offset = '0;
  logic               inv_stage = 1'b0;
  logic               inv_blk = 1'b0;
  logic               inv_inner = 1'b0;
  logic [1:0]         mode = 2'b00;
  logic               advance = 1'b0;
  logic [IDX_W-1:0]   idx;
  logic [2:0]         loop_end;

  logic [IDX_W-1:0] exp_idx_q[$];
  logic [2:0]       exp_end_q[$];
  string            exp_tag_q[$];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft_bfly_sched #(.MAX_LOG2N(MAX_LOG2N), .SHIFT_W(SHIFT_W), .OFF_W(OFF_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .log2n_i     (log2n),
    .stride_sh_i (stride_sh),
    .offset_i    (offset),
    .inv_stage_i (inv_stage),
    .inv_blk_i   (inv_blk),
    .inv_inner_i (inv_inner),
    .mode_i      (mode),
    .advance_i   (advance),
    .idx_o       (idx),
    .loop_end_o  (loop_end)
  );

  task automatic compare(string tag, logic [IDX_W-1:0] e_idx, logic [2:0] e_end);
    checks++;
    if (idx !== e_idx || loop_end !== e_end) begin
      errors++;
      $display("FAIL %s: actual idx=%0d end=%b expected idx=%0d end=%b", tag, idx, loop_end, e_idx, e_end);
    end
  endtask

  // expected stream built from the requirement loops (R2, R3, R4, R5, R6, R7, R8, R9, R11)
  task automatic push_schedule(int lg, int md, int sh, int off, bit is, bit ib, bit ii, int passes, string tag);
    int n;
    n = 1 << lg;
    for (int p = 0; p < passes; p++) begin
      for (int st = 0; st < lg; st++) begin
        int es;
        int span;
        int hs;
        int groups;
        int tstep;
        es = is ? (lg - 1 - st) : st;
        span = 2 << es;
        hs = span / 2;
        groups = n / span;
        tstep = n / span;
        for (int bi = 0; bi < groups; bi++) begin
          int gb;
          gb = ib ? (groups - 1 - bi) : bi;
          for (int ci = 0; ci < hs; ci++) begin
            int ej;
            int j;
            int v;
            logic [2:0] e;
            ej = ii ? (hs - 1 - ci) : ci;
            j = gb * span + ej;
            case (md)
              0: v = j;
              1: v = j + hs;
              2: v = ej * tstep;
              default: v = 0;
            endcase
            e[0] = (ci == hs - 1);
            e[1] = e[0] && (bi == groups - 1);
            e[2] = e[1] && (st == lg - 1);
            exp_idx_q.push_back(IDX_W'(v * (1 << sh) + off));
            exp_end_q.push_back(e);
            exp_tag_q.push_back(tag);
          end
        end
      end
    end
  endtask

  task automatic run_case(int lg, int md, int sh, int off, bit is, bit ib, bit ii,
                          int passes, int hold_at, string tag);
    int total;
    rst_n = 1'b0;
    advance = 1'b0;
    log2n = LG_W'(lg);
    mode = 2'(md);
    stride_sh = SHIFT_W'(sh);
    offset = OFF_W'(off);
    inv_stage = is;
    inv_blk = ib;
    inv_inner = ii;
    push_schedule(lg, md, sh, off, is, ib, ii, passes, tag);
    total = exp_idx_q.size();
    @(negedge clk);
    compare("R1 reset state", exp_idx_q[0], exp_end_q[0]);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1 advance = 1'b1;
    if (hold_at > 0) begin
      repeat (hold_at) @(posedge clk);
      #1 advance = 1'b0;
      repeat (3) @(posedge clk);
      #1 advance = 1'b1;
      repeat (total - hold_at) @(posedge clk);
    end else begin
      repeat (total) @(posedge clk);
    end
    #1 advance = 1'b0;
    if (exp_idx_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R11 %s: actual %0d items left, expected 0", tag, exp_idx_q.size());
      exp_idx_q.delete();
      exp_end_q.delete();
      exp_tag_q.delete();
    end
  endtask

  // monitor: consume one item per advancing edge; while stalled the front item must stay shown
  always @(negedge clk) begin
    if (rst_n && exp_idx_q.size() > 0) begin
      if (advance) begin
        compare(exp_tag_q[0], exp_idx_q[0], exp_end_q[0]);
        void'(exp_idx_q.pop_front());
        void'(exp_end_q.pop_front());
        void'(exp_tag_q.pop_front());
      end else begin
        compare("R10 stall hold", exp_idx_q[0], exp_end_q[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R11 watchdog: actual run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R2 R3 R9 R11: 8 points, lower leg, two passes to see the restart
    run_case(3, 0, 0, 0,    1'b0, 1'b0, 1'b0, 2, 5, "R2 R3 R9 R11 low leg n=8");
    // R4 R5: upper leg, stride 2, offset 5, stall mid-stream
    run_case(4, 1, 1, 5,    1'b0, 1'b0, 1'b0, 1, 9, "R4 R5 high leg n=16");
    // R2 R3: twiddle stream, restart of k in each group
    run_case(4, 2, 0, 0,    1'b0, 1'b0, 1'b0, 1, 0, "R2 R3 twiddle n=16");
    // R4: unused code gives the offset only
    run_case(3, 3, 2, 77,   1'b0, 1'b0, 1'b0, 1, 0, "R4 mode 11");
    // R6: stages from span n down to 2
    run_case(4, 0, 0, 0,    1'b1, 1'b0, 1'b0, 1, 0, "R6 stage invert");
    // R7: groups from the top down
    run_case(4, 1, 0, 0,    1'b0, 1'b1, 1'b0, 1, 0, "R7 group invert");
    // R8 R5: inner reversed, pairing kept, max shift
    run_case(5, 2, 3, 100,  1'b0, 1'b0, 1'b1, 1, 0, "R8 R5 inner invert");
    // R12 R6 R7 R8: largest size, all flags, high offset
    run_case(6, 0, 2, 1000, 1'b1, 1'b1, 1'b1, 1, 40, "R12 R6 R7 R8 n=64");
    // R12 R11: smallest size, single butterfly per pass
    run_case(1, 1, 0, 3,    1'b0, 1'b0, 1'b0, 3, 0, "R12 R11 n=2");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule